// File: doc/BRIEF.md
# ECC-Driven In-Field Word Repair Controller

This controller sits between a host port and a word-organised memory whose words are protected by a single-error-correct, double-error-detect code. Next to the main array is a small pool of spare words. In normal service the controller forwards every host read or write to the memory in the same cycle. An address that has been remapped is steered to its spare word by combinational logic, so normal service costs no extra cycles. The code encoder and decoder, the arrays and any self-test logic sit outside the block. The controller sees the decoder only as corrected data plus two error flags, returned one cycle after a read is issued.

When a host read comes back with a correctable error, the host still gets the corrected word in that cycle. The controller then takes the memory for itself. It writes the corrected word back to the same physical location and reads that location again. A clean re-read means the fault was transient, and service resumes with no remapping. A re-read that still shows an error means the fault is permanent. The controller then binds the logical address to the lowest free spare and stores the corrected word there. If the failing location was already a spare, that spare is retired for good before a new one is chosen. When no spare is left, a sticky flag is raised and the address stays on ECC correction alone. An uncorrectable result only pulses an error output; nothing is rewritten.

Top module: `ecc_word_repair`

## Requirements
- R1: With no error, a read accepted in cycle t (h_req=1, h_we=0, h_busy=0) drives m_en=1, m_we=0 in cycle t and returns h_rvalid=1 with h_rdata equal to the decoder data in cycle t+1, while h_busy stays 0; unmapped addresses go to the main array (m_spare=0).
- R2: On a host read result with d_single=1, the host receives the corrected data in that cycle, h_busy rises in that same cycle, and the controller then writes the captured word back to the same physical location and re-reads it.
- R3: If the re-read is clean (d_single=0, d_double=0), no remap is made and h_busy stays high for exactly 4 cycles, counted from the result cycle.
- R4: If the re-read of a main-array word still reports an error, the controller binds the address to the lowest-index spare that is neither in use nor retired, writes the corrected word into it, and holds h_busy high for exactly 5 cycles.
- R5: A later read or write to a remapped address is issued in the same cycle with m_spare=1 and m_sidx equal to the bound spare index, and the data written there is the data later returned.
- R6: If the persistent error is in a spare already in use, that spare is retired and never allocated again, and the address is rebound to the lowest usable spare.
- R7: If a permanent fault is found and no usable spare remains, repair_exhausted is set and stays set until reset, no remap is made, h_busy lasts 4 cycles, and the host still receives corrected data.
- R8: A read result with d_double=1 and d_single=0 raises h_uncorr for exactly one cycle, with no write-back (h_busy stays 0) and no remap.
- R9: While h_busy is 1, host requests are ignored: the memory is not accessed for them and the addressed word keeps its old contents.
- R10: After reset, h_busy, h_rvalid, h_uncorr, repair_exhausted and m_en are all 0 and no address is remapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW | Host word address |
| h_wdata | input | DW | Host write data |
| h_busy | output | 1 | Memory held by the repair sequence; requests ignored |
| h_rvalid | output | 1 | Read data valid (cycle after acceptance) |
| h_rdata | output | DW | Corrected read data |
| h_uncorr | output | 1 | One-cycle uncorrectable-error pulse |
| repair_exhausted | output | 1 | Sticky: a permanent fault found no usable spare |
| m_en | output | 1 | Memory access enable |
| m_we | output | 1 | Memory write enable |
| m_spare | output | 1 | Access targets the spare pool |
| m_sidx | output | SIW | Spare index when m_spare=1 |
| m_addr | output | AW | Main-array word address |
| m_wdata | output | DW | Memory write data |
| d_data | input | DW | Corrected data from the decoder, cycle after a read |
| d_single | input | 1 | Decoder: correctable single-bit error |
| d_double | input | 1 | Decoder: uncorrectable error |

## Verification
The bench tells transient faults from permanent ones by exact busy length: 4 cycles for a transient fault and 5 for a repair. A design that skipped the re-read, or remapped every corrected error, would show the wrong length and the wrong steering on the next access. It plants a permanent fault inside a spare that is already in use and checks that the address moves to the next spare and that the retired index is never reused. A design that reused it would steer to index 0 again. It then uses up the pool and checks that the flag is sticky and that no remap happens. It also drives a write into the busy window. A design that let it through would corrupt the word seen on a later read.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WBACK  = 3'd1,
    ST_REREAD = 3'd2,
    ST_CHECK  = 3'd3,
    ST_SPWR   = 3'd4
  } ewr_state_e;
endpackage

// File: rtl/ewr_spare_table.sv
module ewr_spare_table #(
  parameter int AW     = 10,
  parameter int NSPARE = 8,
  parameter int SIW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  lk_addr,
  output logic           lk_hit,
  output logic [SIW-1:0] lk_idx,
  output logic           free_ok,
  output logic [SIW-1:0] free_idx,
  input  logic           alloc_en,
  input  logic [AW-1:0]  alloc_addr,
  input  logic           mark_en,
  input  logic [SIW-1:0] mark_idx
);
  logic [NSPARE-1:0] valid_q, valid_d;
  logic [NSPARE-1:0] faulty_q, faulty_d;
  logic [AW-1:0]     addr_q [NSPARE];
  logic [NSPARE-1:0] hit_vec;
  logic [NSPARE-1:0] usable_free;

  // per-entry compare and availability
  for (genvar g = 0; g < NSPARE; g++) begin : g_entry
    assign hit_vec[g]     = valid_q[g] && !faulty_q[g] && (addr_q[g] == lk_addr);
    assign usable_free[g] = !valid_q[g] && !faulty_q[g];
  end

  // highest matching index wins: newest remap has priority
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = 0; i < NSPARE; i++) begin
      if (hit_vec[i]) begin
        lk_hit = 1'b1;
        lk_idx = SIW'(i);
      end
    end
  end

  // lowest usable index is allocated first
  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = NSPARE - 1; i >= 0; i--) begin
      if (usable_free[i]) begin
        free_ok  = 1'b1;
        free_idx = SIW'(i);
      end
    end
  end

  always_comb begin
    valid_d  = valid_q;
    faulty_d = faulty_q;
    if (alloc_en) valid_d[free_idx]  = 1'b1;
    if (mark_en)  faulty_d[mark_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      faulty_q <= '0;
    end else begin
      valid_q  <= valid_d;
      faulty_q <= faulty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSPARE; i++) addr_q[i] <= '0;
    end else if (alloc_en) begin
      addr_q[free_idx] <= alloc_addr;
    end
  end

  AST_ALLOC_HAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_ok); // R4
  AST_MARK_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> valid_q[mark_idx]); // R6
  AST_RETIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((faulty_q & $past(faulty_q)) == $past(faulty_q))); // R6
endmodule

// File: rtl/ewr_seq.sv
module ewr_seq
  import ewr_pkg::*;
#(
  parameter int AW  = 10,
  parameter int DW  = 32,
  parameter int SIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_rd_fire,
  input  logic [AW-1:0]  host_addr,
  input  logic           host_spare,
  input  logic [SIW-1:0] host_sidx,
  input  logic [DW-1:0]  d_data,
  input  logic           d_single,
  input  logic           d_double,
  input  logic           free_ok,
  input  logic [SIW-1:0] free_idx,
  output logic           busy,
  output logic           active,
  output logic           rd_pend,
  output logic           uncorr,
  output logic           exhausted,
  output logic           op_en,
  output logic           op_we,
  output logic           op_spare,
  output logic [SIW-1:0] op_sidx,
  output logic [AW-1:0]  op_addr,
  output logic [DW-1:0]  op_data,
  output logic           alloc_en,
  output logic           mark_en,
  output logic [SIW-1:0] mark_idx
);
  ewr_state_e     state_q, state_d;
  logic           pend_q;
  logic [AW-1:0]  loc_addr_q;
  logic           loc_spare_q;
  logic [SIW-1:0] loc_sidx_q;
  logic [DW-1:0]  cdata_q;
  logic [SIW-1:0] nsidx_q, nsidx_d;
  logic           exh_q, exh_d;
  logic           cap_en;
  logic           hard_seen;

  assign cap_en    = (state_q == ST_IDLE) && pend_q && d_single;
  assign hard_seen = d_single || d_double;

  always_comb begin
    state_d  = state_q;
    nsidx_d  = nsidx_q;
    exh_d    = exh_q;
    alloc_en = 1'b0;
    mark_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (cap_en) state_d = ST_WBACK;
      ST_WBACK:  state_d = ST_REREAD;
      ST_REREAD: state_d = ST_CHECK;
      ST_CHECK: begin
        state_d = ST_IDLE;
        if (hard_seen) begin
          mark_en = loc_spare_q;
          if (free_ok) begin
            alloc_en = 1'b1;
            nsidx_d  = free_idx;
            state_d  = ST_SPWR;
          end else begin
            exh_d = 1'b1;
          end
        end
      end
      ST_SPWR:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      nsidx_q <= '0;
      exh_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= host_rd_fire;
      nsidx_q <= nsidx_d;
      exh_q   <= exh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_addr_q  <= '0;
      loc_spare_q <= 1'b0;
      loc_sidx_q  <= '0;
    end else if (host_rd_fire) begin
      loc_addr_q  <= host_addr;
      loc_spare_q <= host_spare;
      loc_sidx_q  <= host_sidx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cdata_q <= '0;
    else if (cap_en) cdata_q <= d_data;
  end

  assign active    = (state_q != ST_IDLE);
  assign busy      = active || cap_en;
  assign rd_pend   = pend_q;
  assign uncorr    = pend_q && d_double && !d_single;
  assign exhausted = exh_q;

  assign op_en    = (state_q == ST_WBACK) || (state_q == ST_REREAD) || (state_q == ST_SPWR);
  assign op_we    = (state_q == ST_WBACK) || (state_q == ST_SPWR);
  assign op_spare = (state_q == ST_SPWR) ? 1'b1 : loc_spare_q;
  assign op_sidx  = (state_q == ST_SPWR) ? nsidx_q : loc_sidx_q;
  assign op_addr  = loc_addr_q;
  assign op_data  = cdata_q;
  assign mark_idx = loc_sidx_q;

  AST_WB_THEN_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK) |=> (state_q == ST_REREAD)); // R2
  AST_UNC_NO_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |=> (state_q == ST_IDLE)); // R8
  AST_EXH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    exh_q |=> exh_q); // R7
  AST_CHECK_AFTER_REREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |-> ($past(state_q) == ST_REREAD)); // R2
endmodule

// File: rtl/ecc_word_repair.sv
module ecc_word_repair #(
  parameter  int AW     = 10,
  parameter  int DW     = 32,
  parameter  int NSPARE = 8,
  localparam int SIW    = (NSPARE > 1) ? $clog2(NSPARE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_req,
  input  logic           h_we,
  input  logic [AW-1:0]  h_addr,
  input  logic [DW-1:0]  h_wdata,
  output logic           h_busy,
  output logic           h_rvalid,
  output logic [DW-1:0]  h_rdata,
  output logic           h_uncorr,
  output logic           repair_exhausted,
  output logic           m_en,
  output logic           m_we,
  output logic           m_spare,
  output logic [SIW-1:0] m_sidx,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  d_data,
  input  logic           d_single,
  input  logic           d_double
);
  logic           busy, active, rd_pend;
  logic           lk_hit, free_ok, alloc_en, mark_en;
  logic [SIW-1:0] lk_idx, free_idx, mark_idx;
  logic           op_en, op_we, op_spare;
  logic [SIW-1:0] op_sidx;
  logic [AW-1:0]  op_addr;
  logic [DW-1:0]  op_data;
  logic           host_fire, host_rd_fire;

  assign host_fire    = h_req && !busy;
  assign host_rd_fire = host_fire && !h_we;

  ewr_spare_table #(.AW(AW), .NSPARE(NSPARE), .SIW(SIW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_addr    (h_addr),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .free_ok    (free_ok),
    .free_idx   (free_idx),
    .alloc_en   (alloc_en),
    .alloc_addr (op_addr),
    .mark_en    (mark_en),
    .mark_idx   (mark_idx)
  );

  ewr_seq #(.AW(AW), .DW(DW), .SIW(SIW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rd_fire (host_rd_fire),
    .host_addr    (h_addr),
    .host_spare   (lk_hit),
    .host_sidx    (lk_idx),
    .d_data       (d_data),
    .d_single     (d_single),
    .d_double     (d_double),
    .free_ok      (free_ok),
    .free_idx     (free_idx),
    .busy         (busy),
    .active       (active),
    .rd_pend      (rd_pend),
    .uncorr       (h_uncorr),
    .exhausted    (repair_exhausted),
    .op_en        (op_en),
    .op_we        (op_we),
    .op_spare     (op_spare),
    .op_sidx      (op_sidx),
    .op_addr      (op_addr),
    .op_data      (op_data),
    .alloc_en     (alloc_en),
    .mark_en      (mark_en),
    .mark_idx     (mark_idx)
  );

  // memory port: sequencer owns it while active, else host with steering
  always_comb begin
    if (active) begin
      m_en    = op_en;
      m_we    = op_we;
      m_spare = op_spare;
      m_sidx  = op_sidx;
      m_addr  = op_addr;
      m_wdata = op_data;
    end else begin
      m_en    = host_fire;
      m_we    = h_we;
      m_spare = lk_hit;
      m_sidx  = lk_idx;
      m_addr  = h_addr;
      m_wdata = h_wdata;
    end
  end

  assign h_busy   = busy;
  assign h_rvalid = rd_pend;
  assign h_rdata  = d_data;

  AST_READ_RETURNS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we && !h_busy) |=> h_rvalid); // R1
  AST_NO_ACCESS_IN_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_busy && !active) |-> !m_en); // R9
endmodule

// File: tb/ecc_word_repair_bench.sv
module ecc_word_repair_bench;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NS = 8;
  localparam int NW = 1 << AW;

  logic clk, rst_n;
  logic h_req, h_we;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata;
  logic h_busy, h_rvalid, h_uncorr, repair_exhausted;
  logic [DW-1:0] h_rdata;
  logic m_en, m_we, m_spare;
  logic [2:0] m_sidx;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] d_data;
  logic d_single, d_double;

  ecc_word_repair #(.AW(AW), .DW(DW), .NSPARE(NS)) u_ecc_word_repair (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_busy(h_busy), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .h_uncorr(h_uncorr), .repair_exhausted(repair_exhausted), .m_en(m_en),
    .m_we(m_we), .m_spare(m_spare), .m_sidx(m_sidx), .m_addr(m_addr),
    .m_wdata(m_wdata), .d_data(d_data), .d_single(d_single), .d_double(d_double)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- memory + decoder environment ----------------
  logic [DW-1:0] main_mem [NW];
  logic [DW-1:0] sp_mem [NS];
  bit hard_main [NW];
  bit soft_main [NW];
  bit dbl_main  [NW];
  bit hard_sp   [NS];
  logic inj_en;
  int   inj_kind;   // 0 soft main, 1 hard main, 2 double main, 3 hard spare
  int   inj_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        hard_main[i] <= 1'b0; soft_main[i] <= 1'b0; dbl_main[i] <= 1'b0;
      end
      for (int i = 0; i < NS; i++) hard_sp[i] <= 1'b0;
      d_single <= 1'b0; d_double <= 1'b0; d_data <= '0;
    end else begin
      d_single <= 1'b0;
      d_double <= 1'b0;
      if (inj_en) begin
        case (inj_kind)
          0: soft_main[inj_addr] <= 1'b1;
          1: hard_main[inj_addr] <= 1'b1;
          2: dbl_main[inj_addr]  <= 1'b1;
          default: hard_sp[inj_addr] <= 1'b1;
        endcase
      end
      if (m_en) begin
        if (m_we) begin
          if (m_spare) sp_mem[m_sidx] <= m_wdata;
          else begin
            main_mem[m_addr]  <= m_wdata;
            soft_main[m_addr] <= 1'b0;
            dbl_main[m_addr]  <= 1'b0;
          end
        end else if (m_spare) begin
          d_data   <= sp_mem[m_sidx];
          d_single <= hard_sp[m_sidx];
        end else begin
          d_data   <= main_mem[m_addr];
          d_single <= hard_main[m_addr] | soft_main[m_addr];
          d_double <= dbl_main[m_addr] & !(hard_main[m_addr] | soft_main[m_addr]);
        end
      end
    end
  end

  // ---------------- reference model state ----------------
  int remap [int];
  int sp_state [NS];   // 0 free, 1 in use, 2 retired
  bit exp_exh;
  logic [DW-1:0] exp_mem [int];

  int n_run, n_fail, wd_fail;
  bit done;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run + wd_fail, n_fail + wd_fail);
  endtask

  int cyc;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic inject(input int kind, input int a);
    @(negedge clk);
    inj_en = 1'b1; inj_kind = kind; inj_addr = a;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic host_write(input int a, input logic [DW-1:0] d, input string req);
    int k;
    k = remap.exists(a) ? remap[a] : -1;
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b1; h_addr = AW'(a); h_wdata = d;
    #1;
    chk(req, "write m_en", 64'(m_en), 64'(1));
    chk(req, "write m_spare", 64'(m_spare), 64'(k >= 0));
    if (k >= 0) chk(req, "write m_sidx", 64'(m_sidx), 64'(k));
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
    exp_mem[a] = d;
  endtask

  task automatic host_read(input int a, input string req);
    int k, busy_exp, busy_cnt, j;
    bit single, hard, dbl;
    k = remap.exists(a) ? remap[a] : -1;
    single = (k >= 0) ? hard_sp[k] : (hard_main[a] | soft_main[a]);
    hard   = (k >= 0) ? hard_sp[k] : hard_main[a];
    dbl    = (k < 0) && dbl_main[a] && !single;
    busy_exp = 0;
    if (single) begin
      busy_exp = 4;
      if (hard) begin
        if (k >= 0) begin sp_state[k] = 2; remap.delete(a); end
        j = -1;
        for (int i = NS - 1; i >= 0; i--) if (sp_state[i] == 0) j = i;
        if (j >= 0) begin sp_state[j] = 1; remap[a] = j; busy_exp = 5; end
        else exp_exh = 1'b1;
      end
    end
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b0; h_addr = AW'(a);
    #1;
    chk("R1", "read issue m_en", 64'(m_en), 64'(1));
    chk(req, "read m_spare", 64'(m_spare), 64'(k >= 0));
    if (k >= 0) chk(req, "read m_sidx", 64'(m_sidx), 64'(k));
    @(negedge clk);
    h_req = 1'b0;
    chk("R1", "h_rvalid", 64'(h_rvalid), 64'(1));
    if (!dbl) chk(req, "h_rdata", 64'(h_rdata), 64'(exp_mem[a]));
    chk("R8", "h_uncorr", 64'(h_uncorr), 64'(dbl));
    busy_cnt = 0;
    while (h_busy && busy_cnt < 20) begin
      busy_cnt++;
      @(negedge clk);
    end
    chk(req, "busy cycles", 64'(busy_cnt), 64'(busy_exp));
    chk("R7", "repair_exhausted", 64'(repair_exhausted), 64'(exp_exh));
    if (dbl) begin
      @(negedge clk);
      chk("R8", "h_uncorr one cycle", 64'(h_uncorr), 64'(0));
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; wd_fail = 0; done = 1'b0; cyc = 0;
    rst_n = 1'b0; h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0;
    inj_en = 1'b0; inj_kind = 0; inj_addr = 0; exp_exh = 1'b0;
    for (int i = 0; i < NS; i++) sp_state[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "h_busy", 64'(h_busy), 64'(0));
    chk("R10", "h_rvalid", 64'(h_rvalid), 64'(0));
    chk("R10", "h_uncorr", 64'(h_uncorr), 64'(0));
    chk("R10", "repair_exhausted", 64'(repair_exhausted), 64'(0));
    chk("R10", "m_en", 64'(m_en), 64'(0));

    for (int i = 0; i < 32; i++) host_write(i, 32'hA5000000 + 32'(i * 7919), "R1");

    // R1 clean reads, unmapped
    host_read(5, "R1");
    host_read(0, "R1");

    // R2/R3 transient fault
    inject(0, 3);
    host_read(3, "R3");
    host_read(3, "R3");

    // R9 request during busy is ignored
    inject(0, 4);
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b0; h_addr = AW'(4);
    @(negedge clk);
    h_we = 1'b1; h_addr = AW'(12); h_wdata = 32'hDEADBEEF;
    #1;
    chk("R9", "h_busy in result cycle", 64'(h_busy), 64'(1));
    chk("R9", "no access in result cycle", 64'(m_en), 64'(0));
    chk("R2", "corrected data to host", 64'(h_rdata), 64'(exp_mem[4]));
    @(negedge clk);
    chk("R2", "write-back addr", 64'(m_addr), 64'(4));
    chk("R2", "write-back is write", 64'(m_we), 64'(1));
    h_req = 1'b0; h_we = 1'b0;
    repeat (4) @(negedge clk);
    host_read(12, "R9");

    // R4 permanent fault in main
    inject(1, 7);
    host_read(7, "R4");
    host_read(7, "R5");
    host_write(7, 32'h0BADF00D, "R5");
    host_read(7, "R5");

    // R8 uncorrectable
    inject(2, 9);
    host_read(9, "R8");
    host_write(9, 32'h12345678, "R8");
    host_read(9, "R8");

    // R6 permanent fault inside spare 0 (bound to address 7)
    inject(3, 0);
    host_read(7, "R6");
    host_read(7, "R6");

    // fill remaining spares, never reusing retired index 0
    for (int a = 20; a < 26; a++) begin
      inject(1, a);
      host_read(a, "R6");
    end
    host_read(20, "R6");

    // R7 pool exhausted
    inject(1, 26);
    host_read(26, "R7");
    host_read(26, "R7");
    host_read(25, "R5");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule